// File: doc/BRIEF.md
# Frame-Aligned Sample Phase Counter with Silence-Gated Resynchronization

This block is part of the digital core of an audio converter. It runs a sample-phase counter on the oversampling clock, 256 counts per sample period. The counter is meant to stay in step with an external frame clock. That clock is the word-select clock in PCM mode, or a separate word clock when an external digital filter feeds the core. In normal running the counter free-runs and is never disturbed, so the audio path sees no glitch.

The block re-checks alignment only in two cases. The first is a long silence, where both channels read exactly zero for 8192 consecutive sample strobes. The silence can come from zero input or from upstream attenuation; both count the same. The second is the soft-reset control bit held low. In either case, each selected reference edge compares the counter with a tolerance window around zero. If the counter is outside the window, it is re-based to the edge and the sample outputs are blanked for about two sample periods. If the counter is already inside the window, nothing happens. A master enable turns the whole mechanism off.

Top module: `frame_phase_aligner`

## Requirements
- R1: `zero_l` and `zero_r` go high on the first cycle after the 8192th consecutive strobe in which `l_in` and `r_in` are both zero. They stay low after any shorter run.
- R2: The zero-run count saturates, so the flags stay high while zero strobes continue. A strobe carrying a nonzero value on either channel drops both flags on the following cycle.
- R3: `phase` reads 0 during reset. Otherwise it advances by one every clock and wraps from 255 to 0.
- R4: A resynchronization is armed only while `sync_en`=1 and either the zero flags are high or `soft_run`=0. When not armed, reference edges never disturb `phase`.
- R5: The reference edge is chosen as follows: `ext_mode`=0, `fall_sel`=0 selects the rising edge of `lr_clk`; `ext_mode`=0, `fall_sel`=1 selects the falling edge of `lr_clk`; `ext_mode`=1 selects the rising edge of `wd_clk`. Edges of the other clock, and the opposite edge of the selected clock, are ignored.
- R6: A reference edge passes through a two-flop synchronizer and an edge register. It is detected while `phase` holds the value it had just before the raw edge, plus 2. On a realignment, `realign` pulses in the detection cycle and `phase` reads 1 on the next cycle. After that, `phase` reads 254 just before each raw reference edge.
- R7: No realignment occurs when the detected value is within ±4 of zero (252..255 or 0..4). Any value from 5 to 251 triggers one.
- R8: From the cycle after a realignment until the counter has wrapped twice (511 cycles), `l_out` and `r_out` read zero. Strobes taken during that interval store zero.
- R9: Outside blanking, a sample presented with `smp_stb`=1 appears on `l_out`/`r_out` on the next cycle and is held until the next strobe.
- R10: With `sync_en`=0, no realignment ever occurs, whatever the data or `soft_run` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 256 per sample period |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_clk | input | 1 | Word-select frame clock (PCM mode) |
| wd_clk | input | 1 | Word clock (external-filter mode) |
| ext_mode | input | 1 | 1 selects the word clock as reference |
| fall_sel | input | 1 | In PCM mode, 1 selects the falling edge of `lr_clk` |
| sync_en | input | 1 | Master enable of resynchronization |
| soft_run | input | 1 | Soft-reset bit, low arms resynchronization |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| l_in | input | 32 | Left sample |
| r_in | input | 32 | Right sample |
| zero_l | output | 1 | Left zero-run flag |
| zero_r | output | 1 | Right zero-run flag |
| phase | output | 8 | Sample-phase counter |
| realign | output | 1 | Pulse when the counter is re-based |
| l_out | output | 32 | Gated left sample |
| r_out | output | 32 | Gated right sample |

## Verification
A wrong counter state shows on `phase` at once, and at the next frame it shows as a value other than 254 or the untouched start offset just before the raw reference edge. A faulty arming, window or edge-select term either moves the counter when it should not, or leaves it off by the start offset. Either way it is visible 256 cycles after the first edge. A bad zero-run count shows as a flag rising one strobe early or late, or failing to drop on the cycle after a nonzero strobe. Bad blanking shows as a nonzero output twelve cycles after a realignment, or a stuck zero more than 511 cycles later.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    typedef enum logic [1:0] {
        REF_LR_RISE = 2'd0,
        REF_LR_FALL = 2'd1,
        REF_WD_RISE = 2'd2
    } ref_sel_e;

endpackage

// File: rtl/fpa_edge_detect.sv
module fpa_edge_detect
    import fpa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lr_clk,
    input  logic     wd_clk,
    input  ref_sel_e sel,
    output logic     ref_edge
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] lr_sync;
        logic [SYNC_STAGES-1:0] wd_sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     lvl;

    always_comb begin
        st_d         = st_q;
        st_d.lr_sync = {st_q.lr_sync[TOP-1:0], lr_clk};
        st_d.wd_sync = {st_q.wd_sync[TOP-1:0], wd_clk};
        lvl          = (sel == REF_WD_RISE) ? st_q.wd_sync[TOP] : st_q.lr_sync[TOP];
        st_d.prev    = lvl;
        if (sel == REF_LR_FALL) begin
            ref_edge = !lvl && st_q.prev;
        end else begin
            ref_edge = lvl && !st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: an edge pulse never lasts two cycles
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge && $stable(sel) |=> !ref_edge);

endmodule

// File: rtl/fpa_silence.sv
module fpa_silence #(
    parameter int DW   = 32,
    parameter int ZRUN = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [DW-1:0] l_in,
    input  logic [DW-1:0] r_in,
    output logic          silent
);

    localparam int ZW = $clog2(ZRUN + 1);
    localparam logic [ZW-1:0] ZMAX = ZW'(ZRUN);

    typedef struct packed {
        logic [ZW-1:0] run;
    } sil_st_t;

    sil_st_t st_d, st_q;
    logic    both_zero;

    always_comb begin
        st_d      = st_q;
        both_zero = (l_in == '0) && (r_in == '0);
        if (stb) begin
            if (!both_zero) begin
                st_d.run = '0;
            end else if (st_q.run != ZMAX) begin
                st_d.run = st_q.run + ZW'(1);
            end
        end
        silent = (st_q.run == ZMAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_flag_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb && ((l_in != '0) || (r_in != '0)) |=> !silent);

    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        silent && stb && (l_in == '0) && (r_in == '0) |=> silent);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        silent && !stb |=> silent);

endmodule

// File: rtl/fpa_phase_ctr.sv
module fpa_phase_ctr #(
    parameter int PH_W        = 8,
    parameter int TOL         = 4,
    parameter int BLANK_WRAPS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_edge,
    input  logic            armed,
    output logic [PH_W-1:0] phase,
    output logic            load,
    output logic            blank
);

    localparam int BW = $clog2(BLANK_WRAPS + 1);
    localparam logic [PH_W-1:0] PMAX = {PH_W{1'b1}};
    localparam logic [PH_W-1:0] LO_LIM = PH_W'(TOL);
    localparam logic [PH_W-1:0] HI_LIM = PH_W'((2 ** PH_W) - TOL);
    localparam logic [BW-1:0] BLANK_INIT = BW'(BLANK_WRAPS);

    typedef struct packed {
        logic [PH_W-1:0] cnt;
        logic [BW-1:0]   blank_left;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   in_window;

    always_comb begin
        st_d      = st_q;
        in_window = (st_q.cnt <= LO_LIM) || (st_q.cnt >= HI_LIM);
        load      = ref_edge && armed && !in_window;
        if (load) begin
            st_d.cnt        = PH_W'(1);
            st_d.blank_left = BLANK_INIT;
        end else begin
            st_d.cnt = st_q.cnt + PH_W'(1);
            if (st_q.blank_left != '0 && st_q.cnt == PMAX) begin
                st_d.blank_left = st_q.blank_left - BW'(1);
            end
        end
        phase = st_q.cnt;
        blank = (st_q.blank_left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_free_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> phase == $past(phase) + PH_W'(1));

    assert_rebase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase == PH_W'(1)) && blank);

endmodule

// File: rtl/frame_phase_aligner.sv
module frame_phase_aligner
    import fpa_pkg::*;
#(
    parameter int DW          = 32,
    parameter int PH_W        = 8,
    parameter int ZRUN        = 8192,
    parameter int TOL         = 4,
    parameter int BLANK_WRAPS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lr_clk,
    input  logic            wd_clk,
    input  logic            ext_mode,
    input  logic            fall_sel,
    input  logic            sync_en,
    input  logic            soft_run,
    input  logic            smp_stb,
    input  logic [DW-1:0]   l_in,
    input  logic [DW-1:0]   r_in,
    output logic            zero_l,
    output logic            zero_r,
    output logic [PH_W-1:0] phase,
    output logic            realign,
    output logic [DW-1:0]   l_out,
    output logic [DW-1:0]   r_out
);

    typedef struct packed {
        logic [DW-1:0] l_hold;
        logic [DW-1:0] r_hold;
    } dat_st_t;

    dat_st_t  dat_d, dat_q;
    ref_sel_e sel;
    logic     ref_edge;
    logic     silent;
    logic     armed;
    logic     blank;

    always_comb begin
        if (ext_mode) begin
            sel = REF_WD_RISE;
        end else if (fall_sel) begin
            sel = REF_LR_FALL;
        end else begin
            sel = REF_LR_RISE;
        end
        armed = sync_en && (silent || !soft_run);
    end

    fpa_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lr_clk  (lr_clk),
        .wd_clk  (wd_clk),
        .sel     (sel),
        .ref_edge(ref_edge)
    );

    fpa_silence #(
        .DW  (DW),
        .ZRUN(ZRUN)
    ) u_sil (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb),
        .l_in  (l_in),
        .r_in  (r_in),
        .silent(silent)
    );

    fpa_phase_ctr #(
        .PH_W       (PH_W),
        .TOL        (TOL),
        .BLANK_WRAPS(BLANK_WRAPS)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_edge(ref_edge),
        .armed   (armed),
        .phase   (phase),
        .load    (realign),
        .blank   (blank)
    );

    always_comb begin
        dat_d = dat_q;
        if (smp_stb) begin
            dat_d.l_hold = blank ? '0 : l_in;
            dat_d.r_hold = blank ? '0 : r_in;
        end
        l_out  = blank ? '0 : dat_q.l_hold;
        r_out  = blank ? '0 : dat_q.r_hold;
        zero_l = silent;
        zero_r = silent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else begin
            dat_q <= dat_d;
        end
    end

    assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> !realign);

    assert_armed_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> (zero_l || !soft_run));

    assert_blank_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (l_out == '0) && (r_out == '0));

    assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !blank && !realign |=> l_out == $past(l_in));

endmodule

// File: tb/sim_frame_phase_aligner.sv
module sim_frame_phase_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lr_clk = 1'b0, wd_clk = 1'b0;
    logic        ext_mode = 1'b0, fall_sel = 1'b0, sync_en = 1'b0, soft_run = 1'b1;
    logic        smp_stb = 1'b0;
    logic [31:0] l_in = '0, r_in = '0;
    logic        zero_l, zero_r, realign;
    logic [7:0]  phase;
    logic [31:0] l_out, r_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_phase_aligner u0 (
        .clk(clk), .rst_n(rst_n), .lr_clk(lr_clk), .wd_clk(wd_clk),
        .ext_mode(ext_mode), .fall_sel(fall_sel), .sync_en(sync_en),
        .soft_run(soft_run), .smp_stb(smp_stb), .l_in(l_in), .r_in(r_in),
        .zero_l(zero_l), .zero_r(zero_r), .phase(phase), .realign(realign),
        .l_out(l_out), .r_out(r_out)
    );

    // fields: ext, fall, en, soft, silent, expect_realign, offset[7:0]
    localparam logic [13:0] VEC [0:12] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd100},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd254},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd250},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd249},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd3},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd100},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd100},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd60},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd180},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd30},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd200},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd30}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic zero_strobes(input int n);
        l_in = '0;
        r_in = '0;
        for (int k = 0; k < n; k++) begin
            smp_stb = 1'b1;
            tick();
        end
        smp_stb = 1'b0;
        tick();
    endtask

    task automatic one_strobe(input logic [31:0] lv, input logic [31:0] rv);
        l_in = lv;
        r_in = rv;
        smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
        l_in = '0;
        r_in = '0;
    endtask

    // drive the selected clock to its active or inactive level
    task automatic drive_sel(input logic active, input logic ext, input logic fall);
        if (ext) wd_clk = active;
        else if (fall) lr_clk = !active;
        else lr_clk = active;
    endtask

    task automatic drive_other(input logic v, input logic ext);
        if (ext) lr_clk = v;
        else wd_clk = v;
    endtask

    task automatic run_vec(input int i);
        logic       ext, fall, sil, expr;
        logic [7:0] off;
        logic [31:0] dl, dr;
        ext = VEC[i][13]; fall = VEC[i][12];
        sync_en = VEC[i][11]; soft_run = VEC[i][10];
        sil = VEC[i][9]; expr = VEC[i][8]; off = VEC[i][7:0];
        ext_mode = ext; fall_sel = fall;
        lr_clk = fall && !ext; wd_clk = 1'b0;
        do_reset();
        if (sil) begin
            zero_strobes(8192);
            chk("R1 silence flags before realignment", {31'b0, zero_l & zero_r}, 32'd1);
        end
        while (phase != off) tick();
        drive_sel(1'b1, ext, fall);
        dl = 32'hA5A5_0000 + i;
        dr = 32'h0F0F_0100 + i;
        for (int j = 1; j <= 558; j++) begin
            tick();
            if (j == 10) begin
                l_in = dl; r_in = dr; smp_stb = 1'b1;
            end
            if (j == 11) begin
                smp_stb = 1'b0; l_in = '0; r_in = '0;
            end
            if (j == 12) begin
                chk("R8/R9 left output after first edge", l_out, expr ? 32'd0 : dl);
                chk("R8/R9 right output after first edge", r_out, expr ? 32'd0 : dr);
            end
            if (j == 100) drive_other(1'b1, ext);
            if (j == 164) drive_other(1'b0, ext);
            if (j == 128 || j == 384) drive_sel(1'b0, ext, fall);
            if (j == 256) begin
                chk("R4/R5/R6/R7/R10 phase at next reference edge", {24'b0, phase},
                    {24'b0, expr ? 8'd254 : off});
                drive_sel(1'b1, ext, fall);
            end
            if (j == 556) begin
                l_in = ~dl; r_in = ~dr; smp_stb = 1'b1;
            end
            if (j == 557) begin
                smp_stb = 1'b0; l_in = '0; r_in = '0;
            end
            if (j == 558) begin
                chk("R8/R9 output after blanking ends", l_out, ~dl);
                chk("R9 right output after blanking ends", r_out, ~dr);
            end
        end
    endtask

    initial begin
        logic [7:0] p0;
        tick();
        // reset state
        chk("R3 phase during reset", {24'b0, phase}, 32'd0);
        chk("R1 flags during reset", {30'b0, zero_l, zero_r}, 32'd0);
        chk("R9 outputs during reset", l_out | r_out, 32'd0);

        for (int i = 0; i < 13; i++) run_vec(i);

        // directed: counter stepping and wrap
        sync_en = 1'b0; soft_run = 1'b1; ext_mode = 1'b0; fall_sel = 1'b0;
        lr_clk = 1'b0; wd_clk = 1'b0;
        do_reset();
        p0 = phase;
        tick();
        chk("R3 phase steps by one", {24'b0, phase}, {24'b0, p0 + 8'd1});
        while (phase != 8'd255) tick();
        tick();
        chk("R3 phase wraps to zero", {24'b0, phase}, 32'd0);

        // directed: zero-run length and saturation
        zero_strobes(8191);
        chk("R1 flags low after 8191 zero strobes", {30'b0, zero_l, zero_r}, 32'd0);
        zero_strobes(1);
        chk("R1 flags high after 8192 zero strobes", {30'b0, zero_l, zero_r}, 32'd3);
        zero_strobes(300);
        chk("R2 flags stay high while silence lasts", {30'b0, zero_l, zero_r}, 32'd3);
        one_strobe(32'd0, 32'd1);
        chk("R2 right nonzero clears flags next cycle", {30'b0, zero_l, zero_r}, 32'd0);
        zero_strobes(8192);
        one_strobe(32'h8000_0000, 32'd0);
        chk("R2 left nonzero clears flags next cycle", {30'b0, zero_l, zero_r}, 32'd0);
        zero_strobes(8191);
        chk("R1 broken run does not count", {30'b0, zero_l, zero_r}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule